// File: doc/BRIEF.md
# Bidirectional Shift and Load Register

This block is a small register, four bits wide by default, whose contents change on every rising clock edge in one of four ways. A two-bit mode code picks the way: keep the value, move every bit one place towards the low end, move every bit one place towards the high end, or take a whole new word from a parallel input. A synchronous clear beats every mode and empties the register.

A serial bit can enter at either end: a high-end fill bit enters during a move towards the low end, and a low-end fill bit enters during a move towards the high end. The bits at both ends are brought out as serial outputs, and the whole word is also available in parallel. The block suits serial-to-parallel and parallel-to-serial conversion and bidirectional bit streams. Inside, every bit is a cell with a four-source selector. The selector takes the cell itself, its higher neighbour, its lower neighbour or its parallel input bit.

Top module: `ushift_reg`

## Requirements
- R1: The stored word (`word_o`, WIDTH bits, 4 by default) changes only at a rising edge of `clk`. Inputs that change between edges have no effect on the outputs until the next edge.
- R2: With `mode_i` = 0 (keep) and `zero_i` low, the word after the edge equals the word before it.
- R3: With `mode_i` = 1 (towards the low end) and `zero_i` low, bit i takes old bit i+1 for every i below the top, and the top bit (WIDTH-1) takes `fill_hi_i`.
- R4: With `mode_i` = 2 (towards the high end) and `zero_i` low, bit i takes old bit i-1 for every i above 0, and bit 0 takes `fill_lo_i`.
- R5: With `mode_i` = 3 (load) and `zero_i` low, the word after the edge equals `par_i`.
- R6: With `zero_i` high, the word after the edge is all zeros whatever `mode_i`, `par_i` and the fill bits are, including when `mode_i` = 3.
- R7: `hi_o` always equals bit WIDTH-1 of `word_o`, and `lo_o` always equals bit 0.
- R8: Whatever the power-up contents are, one edge with `zero_i` high leaves the register at zero. From then on the contents are fully determined by the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every update happens on its rising edge |
| zero_i | input | 1 | Synchronous clear, active high, overrides the mode |
| mode_i | input | 2 | 0 keep, 1 move towards low end, 2 move towards high end, 3 load |
| fill_hi_i | input | 1 | Serial bit entering the top cell when moving towards the low end |
| fill_lo_i | input | 1 | Serial bit entering cell 0 when moving towards the high end |
| par_i | input | WIDTH | Parallel word taken in load mode |
| word_o | output | WIDTH | Current contents of the register |
| hi_o | output | 1 | Serial output at the high end (bit WIDTH-1) |
| lo_o | output | 1 | Serial output at the low end (bit 0) |

## Verification
The register has no reset apart from the clear. The assertions therefore assume that the clear is asserted at least once before any other behaviour is judged: every mode property stays disabled until an edge with `zero_i` high has been seen. The assertions also assume that `mode_i` and the data inputs are settled at each rising edge. The stimulus applies the clear in its first cycles and changes every input only at the falling edge. It then runs random mode, fill and parallel-word sequences, with directed cases where clear and load come together.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

   typedef enum logic [1:0] {
      MODE_KEEP = 2'd0,
      MODE_DOWN = 2'd1,
      MODE_UP   = 2'd2,
      MODE_LOAD = 2'd3
   } mode_e;

   // one-hot source choice for a bit cell; all zero means clear
   typedef struct packed {
      logic own;
      logic from_hi;
      logic from_lo;
      logic from_par;
   } src_sel_t;

endpackage

// File: rtl/ushift_mode_dec.sv
module ushift_mode_dec
   import ushift_pkg::*;
(
   input  logic       zero_i,
   input  logic [1:0] mode_i,
   output src_sel_t   sel_o
);

   always_comb begin
      sel_o = '0;
      if (!zero_i) begin
         unique case (mode_e'(mode_i))
            MODE_KEEP: sel_o.own      = 1'b1;
            MODE_DOWN: sel_o.from_hi  = 1'b1;
            MODE_UP:   sel_o.from_lo  = 1'b1;
            MODE_LOAD: sel_o.from_par = 1'b1;
            default:   sel_o          = '0;
         endcase
      end
   end

   always_comb begin
      AST_SEL_ONEHOT: assert ($onehot0(sel_o)); // R6
   end

endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
   import ushift_pkg::*;
#(
   parameter bit ANDOR_MUX = 1'b1
)(
   input  logic     clk,
   input  src_sel_t sel_i,
   input  logic     hi_nb_i,
   input  logic     lo_nb_i,
   input  logic     par_i,
   output logic     q_o
);

   logic nxt;

   generate
      if (ANDOR_MUX) begin : g_andor
         assign nxt = (sel_i.own      & q_o)
                    | (sel_i.from_hi  & hi_nb_i)
                    | (sel_i.from_lo  & lo_nb_i)
                    | (sel_i.from_par & par_i);
      end else begin : g_case
         always_comb begin
            unique case (sel_i)
               4'b1000: nxt = q_o;
               4'b0100: nxt = hi_nb_i;
               4'b0010: nxt = lo_nb_i;
               4'b0001: nxt = par_i;
               default: nxt = 1'b0;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      q_o <= nxt;
   end

   AST_CELL_CLEAR: assert property (@(posedge clk)
      (sel_i == '0) |=> (q_o == 1'b0)); // R6

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
   import ushift_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit ANDOR_MUX = 1'b1
)(
   input  logic             clk,
   input  logic             zero_i,
   input  logic [1:0]       mode_i,
   input  logic             fill_hi_i,
   input  logic             fill_lo_i,
   input  logic [WIDTH-1:0] par_i,
   output logic [WIDTH-1:0] word_o,
   output logic             hi_o,
   output logic             lo_o
);

   localparam int TOP = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("ushift_reg: WIDTH must be at least 2");
      end
   endgenerate

   src_sel_t         sel;
   logic [WIDTH-1:0] hi_nb;
   logic [WIDTH-1:0] lo_nb;

   ushift_mode_dec u_dec (
      .zero_i (zero_i),
      .mode_i (mode_i),
      .sel_o  (sel)
   );

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         if (gi == TOP) begin : g_top
            assign hi_nb[gi] = fill_hi_i;
         end else begin : g_mid_hi
            assign hi_nb[gi] = word_o[gi+1];
         end
         if (gi == 0) begin : g_bot
            assign lo_nb[gi] = fill_lo_i;
         end else begin : g_mid_lo
            assign lo_nb[gi] = word_o[gi-1];
         end
         ushift_cell #(.ANDOR_MUX(ANDOR_MUX)) u_cell (
            .clk     (clk),
            .sel_i   (sel),
            .hi_nb_i (hi_nb[gi]),
            .lo_nb_i (lo_nb[gi]),
            .par_i   (par_i[gi]),
            .q_o     (word_o[gi])
         );
      end
   endgenerate

   assign hi_o = word_o[TOP];
   assign lo_o = word_o[0];

   // ---------------- assertions ----------------
   logic armed_q = 1'b0;
   always_ff @(posedge clk) begin
      if (zero_i) armed_q <= 1'b1;
   end

   AST_CLEAR_WINS: assert property (@(posedge clk)
      zero_i |=> (word_o == '0)); // R6

   AST_KEEP: assert property (@(posedge clk) disable iff (!armed_q)
      (!zero_i && mode_i == MODE_KEEP) |=> $stable(word_o)); // R2

   AST_MOVE_DOWN: assert property (@(posedge clk) disable iff (!armed_q)
      (!zero_i && mode_i == MODE_DOWN) |=>
         (word_o == {$past(fill_hi_i), $past(word_o[TOP:1])})); // R3

   AST_MOVE_UP: assert property (@(posedge clk) disable iff (!armed_q)
      (!zero_i && mode_i == MODE_UP) |=>
         (word_o == {$past(word_o[TOP-1:0]), $past(fill_lo_i)})); // R4

   AST_LOAD: assert property (@(posedge clk) disable iff (!armed_q)
      (!zero_i && mode_i == MODE_LOAD) |=> (word_o == $past(par_i))); // R5

endmodule

// File: tb/ushift_reg_tb_top.sv
module ushift_reg_tb_top;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         zero_i = 1'b0;
   logic [1:0]   mode_i = 2'd0;
   logic         fill_hi_i = 1'b0;
   logic         fill_lo_i = 1'b0;
   logic [W-1:0] par_i = '0;
   logic [W-1:0] word_o;
   logic         hi_o;
   logic         lo_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] model = '0;

   always #2.5 clk = ~clk;  // 200 MHz

   ushift_reg #(.WIDTH(W)) dut_i (
      .clk(clk), .zero_i(zero_i), .mode_i(mode_i),
      .fill_hi_i(fill_hi_i), .fill_lo_i(fill_lo_i),
      .par_i(par_i), .word_o(word_o), .hi_o(hi_o), .lo_o(lo_o)
   );

   function automatic logic [W-1:0] next_word(
      logic [W-1:0] q, logic clr, logic [1:0] m,
      logic fh, logic fl, logic [W-1:0] p);
      if (clr) return '0;
      case (m)
         2'd0: return q;
         2'd1: return {fh, q[W-1:1]};
         2'd2: return {q[W-2:0], fl};
         default: return p;
      endcase
   endfunction

   task automatic check(string tag, logic [W-1:0] exp);
      n_chk++;
      if (word_o !== exp) begin
         n_bad++;
         $display("FAIL %s word got %b expected %b", tag, word_o, exp);
      end
      n_chk++;
      if (hi_o !== exp[W-1] || lo_o !== exp[0]) begin
         n_bad++;
         $display("FAIL R7 (%s) ends got %b%b expected %b%b",
                  tag, hi_o, lo_o, exp[W-1], exp[0]);
      end
   endtask

   // drive at falling edge, apply at rising edge, sample 1 ns later
   task automatic step(string tag, logic clr, logic [1:0] m,
                       logic fh, logic fl, logic [W-1:0] p);
      @(negedge clk);
      zero_i = clr; mode_i = m; fill_hi_i = fh; fill_lo_i = fl; par_i = p;
      @(posedge clk);
      #1;
      model = next_word(model, clr, m, fh, fl, p);
      check(tag, model);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'd1234);
      // R8: one clear from unknown power-up contents
      step("R8", 1'b1, 2'd2, 1'b1, 1'b1, 4'hF);
      step("R2", 1'b0, 2'd0, 1'b1, 1'b1, 4'hF);
      // R5 loads and R3/R4 serial paths
      step("R5", 1'b0, 2'd3, 1'b0, 1'b0, 4'b1001);
      step("R3", 1'b0, 2'd1, 1'b1, 1'b0, 4'h0);
      step("R3", 1'b0, 2'd1, 1'b0, 1'b1, 4'h0);
      step("R4", 1'b0, 2'd2, 1'b0, 1'b1, 4'h0);
      step("R4", 1'b0, 2'd2, 1'b1, 1'b0, 4'h0);
      // fill all ones from the high end, then empty via low end
      for (int i = 0; i < W; i++) step("R3", 1'b0, 2'd1, 1'b1, 1'b0, 4'h0);
      for (int i = 0; i < W; i++) step("R4", 1'b0, 2'd2, 1'b0, 1'b0, 4'hF);
      // R6: clear together with load and with every other mode
      step("R5", 1'b0, 2'd3, 1'b0, 1'b0, 4'hA);
      step("R6", 1'b1, 2'd3, 1'b1, 1'b1, 4'hF);
      step("R5", 1'b0, 2'd3, 1'b0, 1'b0, 4'h7);
      step("R6", 1'b1, 2'd0, 1'b1, 1'b1, 4'hF);
      step("R5", 1'b0, 2'd3, 1'b0, 1'b0, 4'hE);
      step("R6", 1'b1, 2'd1, 1'b1, 1'b1, 4'hF);
      step("R5", 1'b0, 2'd3, 1'b0, 1'b0, 4'hD);
      step("R6", 1'b1, 2'd2, 1'b1, 1'b1, 4'hF);
      // R1: change inputs mid-cycle, no edge yet, output must not move
      step("R5", 1'b0, 2'd3, 1'b0, 1'b0, 4'h5);
      @(negedge clk);
      zero_i = 1'b0; mode_i = 2'd3; par_i = 4'hC;
      #1;
      check("R1", model);
      @(posedge clk);
      #1;
      model = 4'hC;
      check("R1", model);
      // random sequences
      for (int i = 0; i < 400; i++) begin
         logic         c;
         logic [1:0]   m;
         logic [W-1:0] p;
         string        t;
         c = ($urandom % 16) == 0;
         m = 2'($urandom);
         p = W'($urandom);
         if (c) t = "R6";
         else case (m)
            2'd0: t = "R2";
            2'd1: t = "R3";
            2'd2: t = "R4";
            default: t = "R5";
         endcase
         step(t, c, m, 1'($urandom), 1'($urandom), p);
      end
      finish_run();
   end

endmodule